// File: doc/BRIEF.md
# Configuration Readback Scan Chain

This block gives diagnostic software a way to read the live routing configuration back out of the switch, one bit at a time. The configuration memory presents its active bank as a flat vector of 69 slots, 7 bits each. On a serial-clock edge with serial mode on and scan-enable low, the block copies every slot into a 483-bit scan register at once. It does this in parallel, so the snapshot is consistent.

With scan-enable raised, each later serial-clock edge moves the register one place toward the serial output. The highest slot leaves first and slot 0 leaves last. Within each slot the most significant bit leaves first. Zeros enter at the tail, so a reader that clocks past the end sees zeros. When serial mode is off, the register keeps its contents and ignores scan-enable.

Top module: `cfg_scan_readback`

## Requirements
- R1: While reset is asserted and after it is released, the register holds all zeros. Until the first capture, `sdo` reads 0 on every edge, including shift edges.
- R2: A rising `sclk` edge with `ser_mode`=1 and `scan_en`=0 loads every slot from `active_map`. Slot s sits at bits [s*7 +: 7] of that vector. Right after that edge, `sdo` shows bit 6 of slot 68.
- R3: Each rising `sclk` edge with `ser_mode`=1 and `scan_en`=1 moves the register by exactly one bit, and `sdo` then shows the next bit of the readout.
- R4: Slots leave in descending order: all 7 bits of slot 68, then slot 67, and so on down to slot 0.
- R5: Within one slot, bits leave from bit 6 down to bit 0.
- R6: A rising `sclk` edge with `ser_mode`=0 changes nothing, whatever `scan_en` and `active_map` are doing. `sdo` keeps its value.
- R7: Zeros fill the register from the tail. After 483 shift edges and on every later shift edge, `sdo` is 0.
- R8: A capture edge that comes in the middle of a readout discards the rest of that readout. The register reloads from the current `active_map`, and the readout restarts at slot 68, bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_mode | input | 1 | Serial mode select; 0 freezes the register |
| scan_en | input | 1 | 0 captures on the next edge, 1 shifts on the next edge |
| active_map | input | 483 | Active configuration bank, slot s at bits [s*7 +: 7] |
| sdo | output | 1 | Serial readout data |

## Verification
The readout is tried with four bank patterns:
- An identity map, where slot s holds s. Every slot is distinct, so a swapped or skipped slot shows up (R4).
- A scrambled arithmetic map, which puts varied values in the upper bits. This exposes bit reversal within a slot (R5).
- An alternating all-ones/all-zeros map, which makes an off-by-one shift visible at every slot boundary.
- Reads past the end of the register, which show whether zeros fill from the tail (R7).

The bench also freezes the register by dropping serial mode in the middle of a readout while the bank changes (R6). It recaptures partway through a readout (R8), and it shifts before any capture to confirm that reset leaves the register clear (R1).

// File: rtl/cfg_scan_pkg.sv
package cfg_scan_pkg;

    // Operation applied to the scan register on a serial-clock edge
    typedef enum logic [1:0] {
        SC_HOLD    = 2'd0,
        SC_CAPTURE = 2'd1,
        SC_SHIFT   = 2'd2
    } scan_op_e;

endpackage

// File: rtl/scan_op_dec.sv
module scan_op_dec
    import cfg_scan_pkg::*;
(
    input  logic     ser_mode,
    input  logic     scan_en,
    output scan_op_e op
);

    always_comb begin
        if (!ser_mode) begin
            op = SC_HOLD;
        end else if (scan_en) begin
            op = SC_SHIFT;
        end else begin
            op = SC_CAPTURE;
        end
    end

endmodule

// File: rtl/scan_slot_seg.sv
module scan_slot_seg
    import cfg_scan_pkg::*;
#(
    parameter int SLOT_W   = 7,
    parameter bit IS_FIRST = 1'b0
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  scan_op_e          op,
    input  logic [SLOT_W-1:0] par_in,
    input  logic              ser_in,
    output logic              ser_out
);

    typedef struct packed {
        logic [SLOT_W-1:0] bits;
    } seg_state_t;

    seg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            SC_CAPTURE: st_d.bits = par_in;
            SC_SHIFT:   st_d.bits = {st_q.bits[SLOT_W-2:0], ser_in};
            default:    st_d = st_q;
        endcase
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_out = st_q.bits[SLOT_W-1];

    AST_SEG_LOAD: assert property (@(posedge sclk) disable iff (!rst_n)
        (op == SC_CAPTURE) |=> (st_q.bits == $past(par_in))); // R2

    AST_SEG_SHIFT: assert property (@(posedge sclk) disable iff (!rst_n)
        (op == SC_SHIFT) |=> (st_q.bits == {$past(st_q.bits[SLOT_W-2:0]), $past(ser_in)})); // R3

    AST_SEG_FROZEN: assert property (@(posedge sclk) disable iff (!rst_n)
        (op == SC_HOLD) |=> $stable(st_q.bits)); // R6

    generate
        if (IS_FIRST) begin : g_tail
            AST_TAIL_ZERO: assert property (@(posedge sclk) disable iff (!rst_n)
                (op == SC_SHIFT) |=> (st_q.bits[0] == 1'b0)); // R7
        end
    endgenerate

endmodule

// File: rtl/cfg_scan_readback.sv
module cfg_scan_readback
    import cfg_scan_pkg::*;
#(
    parameter int NUM_SLOTS = 69,
    parameter int SLOT_W    = 7
) (
    input  logic                          sclk,
    input  logic                          rst_n,
    input  logic                          ser_mode,
    input  logic                          scan_en,
    input  logic [NUM_SLOTS*SLOT_W-1:0]   active_map,
    output logic                          sdo
);

    localparam int CHAIN_W = NUM_SLOTS * SLOT_W;

    scan_op_e             op;
    logic [NUM_SLOTS-1:0] seg_out;

    scan_op_dec u_dec (
        .ser_mode (ser_mode),
        .scan_en  (scan_en),
        .op       (op)
    );

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            logic seg_in;
            if (s == 0) begin : g_first
                assign seg_in = 1'b0;
            end else begin : g_link
                assign seg_in = seg_out[s-1];
            end
            scan_slot_seg #(
                .SLOT_W   (SLOT_W),
                .IS_FIRST (s == 0)
            ) u_seg (
                .sclk    (sclk),
                .rst_n   (rst_n),
                .op      (op),
                .par_in  (active_map[s*SLOT_W +: SLOT_W]),
                .ser_in  (seg_in),
                .ser_out (seg_out[s])
            );
        end
    endgenerate

    assign sdo = seg_out[NUM_SLOTS-1];

    AST_FIRST_BIT: assert property (@(posedge sclk) disable iff (!rst_n)
        (ser_mode && !scan_en) |=> (sdo == $past(active_map[CHAIN_W-1]))); // R2

    AST_SDO_FROZEN: assert property (@(posedge sclk) disable iff (!rst_n)
        !ser_mode |=> $stable(sdo)); // R6

endmodule

// File: tb/cfg_scan_readback_bench.sv
module cfg_scan_readback_bench;

    localparam int NS = 69;
    localparam int SW = 7;
    localparam int CW = NS * SW;

    logic          sclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_mode = 1'b0;
    logic          scan_en = 1'b0;
    logic [CW-1:0] map = '0;
    logic          sdo;

    logic [CW-1:0] captured = '0;
    int            pos = 0;
    int            n_vec = 0;
    int            n_bad = 0;
    bit            exp_q[$];
    string         tag_q[$];

    cfg_scan_readback u_cfg_scan_readback (
        .sclk       (sclk),
        .rst_n      (rst_n),
        .ser_mode   (ser_mode),
        .scan_en    (scan_en),
        .active_map (map),
        .sdo        (sdo)
    );

    always #2.5 sclk = ~sclk;

    // Expected readout bit k: slot 68 first, bit 6 first, zeros past the end
    function automatic bit exp_bit(logic [CW-1:0] m, int k);
        int slot;
        int b;
        if (k >= CW) return 1'b0;
        slot = NS - 1 - k / SW;
        b    = SW - 1 - k % SW;
        return m[slot*SW + b];
    endfunction

    task automatic push(bit e, string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic capture(string t);
        @(negedge sclk);
        ser_mode = 1'b1;
        scan_en  = 1'b0;
        captured = map;
        pos      = 0;
        push(exp_bit(captured, 0), t);
    endtask

    task automatic shift(int n, string force_tag);
        for (int i = 0; i < n; i++) begin
            string t;
            @(negedge sclk);
            ser_mode = 1'b1;
            scan_en  = 1'b1;
            pos++;
            if (force_tag != "")   t = force_tag;
            else if (pos >= CW)    t = "R7";
            else if (pos == 1)     t = "R3";
            else if (pos % SW == 0) t = "R4";
            else                   t = "R5";
            push(exp_bit(captured, pos), t);
        end
    endtask

    task automatic idle(int n, bit se);
        for (int i = 0; i < n; i++) begin
            @(negedge sclk);
            ser_mode = 1'b0;
            scan_en  = se;
            map      = ~map;
            push(exp_bit(captured, pos), "R6");
        end
    endtask

    // Monitor: compares one expected bit per edge, away from the edge
    always @(posedge sclk) begin
        #1;
        if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (sdo !== e) begin
                n_bad++;
                $display("FAIL %s: sdo=%0b expected %0b", t, sdo, e);
            end
        end
    end

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge sclk);
        n_vec++;
        if (sdo !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: sdo=%0b in reset expected 0", sdo);
        end
        rst_n = 1'b1;
        // R1: no capture yet, shifting yields zeros
        captured = '0;
        pos = 0;
        shift(8, "R1");

        // Identity map: slot s holds s
        for (int s = 0; s < NS; s++) map[s*SW +: SW] = SW'(s);
        capture("R2");
        shift(CW + 3, "");

        // Scrambled map, then freeze while the bank changes
        for (int s = 0; s < NS; s++) map[s*SW +: SW] = SW'((s * 37 + 11) & 127);
        capture("R2");
        shift(20, "");
        idle(4, 1'b1);
        idle(3, 1'b0);
        shift(30, "");

        // R8: recapture mid-readout from a new bank
        for (int s = 0; s < NS; s++) map[s*SW +: SW] = SW'((s * 13 + 90) & 127);
        capture("R8");
        shift(CW + 2, "");

        // Alternating all-ones / all-zeros slots
        for (int s = 0; s < NS; s++) map[s*SW +: SW] = (s % 2 == 0) ? '1 : '0;
        capture("R2");
        shift(CW + 1, "");

        @(negedge sclk);
        ser_mode = 1'b0;
        scan_en  = 1'b0;
        repeat (3) @(negedge sclk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule